// File: doc/BRIEF.md
# Block-Transfer Parameter Registers

This block holds the setup of a 2D block-transfer engine: the two fill colours, the rectangle extent, the row strides of both surfaces, the source and destination start addresses, the operation mode and the raster operation. The host writes it one byte at a time through a memory-mapped port addressed by a byte offset. Each write merges into its field. Some fields are clipped to their legal width, and that width depends on a static variant strap. A second, indexed port reaches a subset of the same bytes under index numbers of its own. The engine consumes the fields as plain parallel outputs.

A write to the control byte with the go bit set launches an operation. For an ordinary launch the block raises a one-cycle start pulse and goes busy. When the mode selects host-supplied source data, the block does not pulse. It snapshots the source and destination addresses, goes busy and waits for host data. A done input from the engine ends either kind of operation. Field writes made while busy still land, but a second go bit is ignored until done arrives.

All ports are plain strobes and levels. Both write ports are always accepted and apply no back-pressure. The strap `wide_sel` is held static outside reset. Byte offsets: background colour 0x00–0x03 and foreground colour 0x04–0x07, least significant byte at the lowest offset. Width is at 0x08 (low) and 0x09 (high). Height is at 0x0A and 0x0B. Destination pitch is at 0x0C and 0x0D, and source pitch at 0x0E and 0x0F. The destination address is at 0x10–0x12 and the source address at 0x14–0x16. Mode is at 0x18, raster op at 0x1A and control at 0x1C.

Top module: `blt_param_regs`

## Requirements
- R1: After reset every field output, every saved address, `start_pulse`, `busy` and `host_wait` read zero.
- R2: A write to offsets 0x00–0x03 (background) or 0x04–0x07 (foreground) replaces colour byte (offset mod 4), byte 0 being bits 7:0. With `wide_sel`=1 the colours are 32 bits wide.
- R3: With `wide_sel`=0 the colours are 16 bits wide. Writes to offsets 0x02, 0x03, 0x06 and 0x07, on either port, leave both colour outputs unchanged.
- R4: Offset 0x08 writes width bits 7:0. Offset 0x09 writes width bits 12:8 from data bits 4:0 when `wide_sel`=1, and writes width bits 10:8 from data bits 2:0 with bits 12:11 cleared when `wide_sel`=0.
- R5: Offset 0x0A writes height bits 7:0. Offset 0x0B writes height bits 9:8 from data bits 1:0.
- R6: Offsets 0x0C and 0x0D write the low and high bytes of the 16-bit destination pitch. Offsets 0x0E and 0x0F do the same for the source pitch.
- R7: Offsets 0x10, 0x11 and 0x12 write destination address bits 7:0, 15:8 and the top byte. Offsets 0x14–0x16 do the same for the source address. The top byte keeps data bits 5:0 (22-bit address) when `wide_sel`=1, and keeps data bits 4:0 with bit 21 cleared (21-bit address) when `wide_sel`=0.
- R8: Offset 0x18 writes the 8-bit mode and offset 0x1A the 8-bit raster op.
- R9: On the indexed port, indices 0x00 and 0x01 reach offsets 0x00 and 0x01, 0x10 and 0x11 reach 0x04 and 0x05, 0x12 reaches 0x02, 0x13 reaches 0x06, 0x14 reaches 0x03, 0x15 reaches 0x07, and 0x20 reaches 0x08, with the same masking as a direct write. Other indices change nothing.
- R10: A write to offset 0x1C with data bit 1 set, while not busy and with mode bit 2 clear, raises `start_pulse` for exactly one cycle after the write edge and sets `busy`. A control write with bit 1 clear does nothing.
- R11: The same go write with mode bit 2 set raises no pulse. It sets `busy` and `host_wait` and copies the current destination and source addresses to `dst_addr_saved` and `src_addr_saved`.
- R12: `op_done` clears `busy` and `host_wait` at the next edge. While busy, field writes still take effect and a go write raises no pulse.
- R13: When both ports write in the same cycle, the memory-mapped write takes effect and the indexed write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_sel | input | 1 | Variant strap: 1 selects the wide field widths |
| mm_we | input | 1 | Memory-mapped byte write strobe |
| mm_addr | input | 8 | Memory-mapped byte offset |
| mm_wdata | input | 8 | Memory-mapped write data |
| gc_we | input | 1 | Indexed-port write strobe |
| gc_index | input | 8 | Indexed-port register index |
| gc_wdata | input | 8 | Indexed-port write data |
| op_done | input | 1 | Engine reports the operation finished |
| bg_color | output | 32 | Background colour |
| fg_color | output | 32 | Foreground colour |
| xfer_width | output | 13 | Rectangle width |
| xfer_height | output | 10 | Rectangle height |
| dst_pitch | output | 16 | Destination row stride |
| src_pitch | output | 16 | Source row stride |
| dst_addr | output | 22 | Destination start address |
| src_addr | output | 22 | Source start address |
| xfer_mode | output | 8 | Mode byte (bit 2: host-supplied source) |
| xfer_rop | output | 8 | Raster operation byte |
| start_pulse | output | 1 | One-cycle launch strobe |
| busy | output | 1 | Operation in progress |
| host_wait | output | 1 | Launched with host source, awaiting data |
| dst_addr_saved | output | 22 | Destination address captured at a host-source launch |
| src_addr_saved | output | 22 | Source address captured at a host-source launch |

## Verification
Every field output, `busy`, `host_wait` and the saved addresses change at the clock edge that samples the write or done strobe. `start_pulse` is high for exactly the cycle after the go write's edge. The bench drives inputs on falling edges and updates a behavioural model on the same rising edge as the design. It compares every output on the following falling edge, so each result is checked in the one cycle it is due. Directed checks with literal expected values are made at the same falling edge, right after each write: masking per variant, ignored narrow colour bytes, alias reach, retrigger blocking and port priority.

// File: rtl/blt_regs_pkg.sv
package blt_regs_pkg;
  // byte offsets on the memory-mapped port
  localparam logic [7:0] OFF_BG        = 8'h00;
  localparam logic [7:0] OFF_FG        = 8'h04;
  localparam logic [7:0] OFF_WID_LO    = 8'h08;
  localparam logic [7:0] OFF_WID_HI    = 8'h09;
  localparam logic [7:0] OFF_HGT_LO    = 8'h0A;
  localparam logic [7:0] OFF_HGT_HI    = 8'h0B;
  localparam logic [7:0] OFF_DPITCH_LO = 8'h0C;
  localparam logic [7:0] OFF_SPITCH_LO = 8'h0E;
  localparam logic [7:0] OFF_DADDR_LO  = 8'h10;
  localparam logic [7:0] OFF_SADDR_LO  = 8'h14;
  localparam logic [7:0] OFF_MODE      = 8'h18;
  localparam logic [7:0] OFF_ROP       = 8'h1A;
  localparam logic [7:0] OFF_CTRL      = 8'h1C;

  localparam int CTRL_GO_BIT       = 1;
  localparam int MODE_HOST_SRC_BIT = 2;

  typedef struct packed {
    logic       en;
    logic [7:0] off;
    logic [7:0] data;
  } byte_wr_t;
endpackage

// File: rtl/blt_alias_map.sv
module blt_alias_map
  import blt_regs_pkg::*;
(
  input  logic [7:0] idx_i,
  output logic       hit_o,
  output logic [7:0] off_o
);
  always_comb begin
    hit_o = 1'b1;
    off_o = OFF_BG;
    case (idx_i)
      8'h00:   off_o = OFF_BG;
      8'h01:   off_o = OFF_BG + 8'd1;
      8'h10:   off_o = OFF_FG;
      8'h11:   off_o = OFF_FG + 8'd1;
      8'h12:   off_o = OFF_BG + 8'd2;
      8'h13:   off_o = OFF_FG + 8'd2;
      8'h14:   off_o = OFF_BG + 8'd3;
      8'h15:   off_o = OFF_FG + 8'd3;
      8'h20:   off_o = OFF_WID_LO;
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/blt_field_bank.sv
module blt_field_bank
  import blt_regs_pkg::*;
#(
  parameter int COLOR_BYTES        = 4,
  parameter int NARROW_COLOR_BYTES = 2,
  parameter int WIDE_WIDTH_BITS    = 13,
  parameter int NARROW_WIDTH_BITS  = 11,
  parameter int HEIGHT_BITS        = 10,
  parameter int PITCH_BITS         = 16,
  parameter int WIDE_ADDR_BITS     = 22,
  parameter int NARROW_ADDR_BITS   = 21,
  localparam int COLOR_W = COLOR_BYTES * 8
)(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wide_sel,
  input  byte_wr_t                  wr,
  output logic [COLOR_W-1:0]        bg_o,
  output logic [COLOR_W-1:0]        fg_o,
  output logic [WIDE_WIDTH_BITS-1:0] width_o,
  output logic [HEIGHT_BITS-1:0]    height_o,
  output logic [PITCH_BITS-1:0]     dst_pitch_o,
  output logic [PITCH_BITS-1:0]     src_pitch_o,
  output logic [WIDE_ADDR_BITS-1:0] dst_addr_o,
  output logic [WIDE_ADDR_BITS-1:0] src_addr_o,
  output logic [7:0]                mode_o,
  output logic [7:0]                rop_o
);
  localparam int WID_HI_W  = WIDE_WIDTH_BITS - 8;
  localparam int WID_NHI_W = NARROW_WIDTH_BITS - 8;
  localparam int HGT_HI_W  = HEIGHT_BITS - 8;
  localparam int PIT_HI_W  = PITCH_BITS - 8;
  localparam int ADR_HI_W  = WIDE_ADDR_BITS - 16;
  localparam int ADR_NHI_W = NARROW_ADDR_BITS - 16;
  localparam logic [WID_HI_W-1:0] WID_NAR_MASK =
    {{(WID_HI_W-WID_NHI_W){1'b0}}, {WID_NHI_W{1'b1}}};
  localparam logic [ADR_HI_W-1:0] ADR_NAR_MASK =
    {{(ADR_HI_W-ADR_NHI_W){1'b0}}, {ADR_NHI_W{1'b1}}};

  function automatic logic [7:0] col_off(input int c, input int b);
    return ((c == 0) ? OFF_BG : OFF_FG) + 8'(b);
  endfunction

  // colours: byte lanes above the narrow width are gated by the strap
  logic [1:0][COLOR_BYTES-1:0][7:0] col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
    end else if (wr.en) begin
      for (int c = 0; c < 2; c++) begin
        for (int b = 0; b < COLOR_BYTES; b++) begin
          if ((wr.off == col_off(c, b)) && (wide_sel || (b < NARROW_COLOR_BYTES)))
            col_q[c][b] <= wr.data;
        end
      end
    end
  end

  assign bg_o = col_q[0];
  assign fg_o = col_q[1];

  // extent, mode and raster op
  logic [7:0]          wid_lo_q, hgt_lo_q, mode_q, rop_q;
  logic [WID_HI_W-1:0] wid_hi_q;
  logic [HGT_HI_W-1:0] hgt_hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_lo_q <= '0;
      wid_hi_q <= '0;
      hgt_lo_q <= '0;
      hgt_hi_q <= '0;
      mode_q   <= '0;
      rop_q    <= '0;
    end else if (wr.en) begin
      case (wr.off)
        OFF_WID_LO: wid_lo_q <= wr.data;
        OFF_WID_HI: wid_hi_q <= wr.data[WID_HI_W-1:0] &
                                (wide_sel ? {WID_HI_W{1'b1}} : WID_NAR_MASK);
        OFF_HGT_LO: hgt_lo_q <= wr.data;
        OFF_HGT_HI: hgt_hi_q <= wr.data[HGT_HI_W-1:0];
        OFF_MODE:   mode_q   <= wr.data;
        OFF_ROP:    rop_q    <= wr.data;
        default: ;
      endcase
    end
  end

  assign width_o  = {wid_hi_q, wid_lo_q};
  assign height_o = {hgt_hi_q, hgt_lo_q};
  assign mode_o   = mode_q;
  assign rop_o    = rop_q;

  // destination (k=0) and source (k=1) pitch and address
  for (genvar k = 0; k < 2; k++) begin : g_surf
    localparam logic [7:0] PIT_BASE = (k == 0) ? OFF_DPITCH_LO : OFF_SPITCH_LO;
    localparam logic [7:0] ADR_BASE = (k == 0) ? OFF_DADDR_LO  : OFF_SADDR_LO;
    logic [7:0]          pit_lo_q, adr_b0_q, adr_b1_q;
    logic [PIT_HI_W-1:0] pit_hi_q;
    logic [ADR_HI_W-1:0] adr_b2_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pit_lo_q <= '0;
        pit_hi_q <= '0;
        adr_b0_q <= '0;
        adr_b1_q <= '0;
        adr_b2_q <= '0;
      end else if (wr.en) begin
        if (wr.off == PIT_BASE)         pit_lo_q <= wr.data;
        if (wr.off == PIT_BASE + 8'd1)  pit_hi_q <= wr.data[PIT_HI_W-1:0];
        if (wr.off == ADR_BASE)         adr_b0_q <= wr.data;
        if (wr.off == ADR_BASE + 8'd1)  adr_b1_q <= wr.data;
        if (wr.off == ADR_BASE + 8'd2)
          adr_b2_q <= wr.data[ADR_HI_W-1:0] &
                      (wide_sel ? {ADR_HI_W{1'b1}} : ADR_NAR_MASK);
      end
    end

    if (k == 0) begin : g_dst
      assign dst_pitch_o = {pit_hi_q, pit_lo_q};
      assign dst_addr_o  = {adr_b2_q, adr_b1_q, adr_b0_q};
    end else begin : g_src
      assign src_pitch_o = {pit_hi_q, pit_lo_q};
      assign src_addr_o  = {adr_b2_q, adr_b1_q, adr_b0_q};
    end
  end

  // R3: narrow variant keeps the upper colour lanes untouched
  assert_narrow_colour_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && !wide_sel &&
     (wr.off == OFF_BG + 8'd2 || wr.off == OFF_BG + 8'd3 ||
      wr.off == OFF_FG + 8'd2 || wr.off == OFF_FG + 8'd3))
    |=> ($stable(bg_o) && $stable(fg_o)));

  // R4: narrow width never exceeds its bit count after a high-byte write
  assert_width_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && !wide_sel && wr.off == OFF_WID_HI)
    |=> (width_o[WIDE_WIDTH_BITS-1:NARROW_WIDTH_BITS] == '0));

  // R7: narrow destination address clipped after a top-byte write
  assert_addr_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && !wide_sel && wr.off == OFF_DADDR_LO + 8'd2)
    |=> (dst_addr_o[WIDE_ADDR_BITS-1:NARROW_ADDR_BITS] == '0));

  // R8: mode byte written through
  assert_mode_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr.en && wr.off == OFF_MODE) |=> (mode_o == $past(wr.data)));
endmodule

// File: rtl/blt_launch_ctl.sv
module blt_launch_ctl
  import blt_regs_pkg::*;
#(
  parameter int ADDR_W = 22
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [7:0]        ctrl_data_i,
  input  logic [7:0]        mode_i,
  input  logic [ADDR_W-1:0] dst_addr_i,
  input  logic [ADDR_W-1:0] src_addr_i,
  input  logic              op_done_i,
  output logic              start_pulse_o,
  output logic              busy_o,
  output logic              host_wait_o,
  output logic [ADDR_W-1:0] dst_saved_o,
  output logic [ADDR_W-1:0] src_saved_o
);
  logic launch, host_src;
  logic busy_q, host_q, pulse_q;
  logic [ADDR_W-1:0] dsv_q, ssv_q;

  assign launch   = ctrl_wr_i && ctrl_data_i[CTRL_GO_BIT] && !busy_q;
  assign host_src = mode_i[MODE_HOST_SRC_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      host_q  <= 1'b0;
      pulse_q <= 1'b0;
      dsv_q   <= '0;
      ssv_q   <= '0;
    end else begin
      pulse_q <= launch && !host_src;
      if (launch) begin
        busy_q <= 1'b1;
        if (host_src) begin
          host_q <= 1'b1;
          dsv_q  <= dst_addr_i;
          ssv_q  <= src_addr_i;
        end
      end else if (op_done_i) begin
        busy_q <= 1'b0;
        host_q <= 1'b0;
      end
    end
  end

  assign start_pulse_o = pulse_q;
  assign busy_o        = busy_q;
  assign host_wait_o   = host_q;
  assign dst_saved_o   = dsv_q;
  assign src_saved_o   = ssv_q;

  // R10: the launch strobe lasts one cycle and comes with busy
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |=> !start_pulse_o);
  assert_pulse_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse_o |-> busy_o);

  // R11: host-source launch snapshots addresses and does not pulse
  assert_host_launch_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && ctrl_data_i[CTRL_GO_BIT] && !busy_o && mode_i[MODE_HOST_SRC_BIT])
    |=> (host_wait_o && !start_pulse_o && dst_saved_o == $past(dst_addr_i)
         && src_saved_o == $past(src_addr_i)));

  // R12: no retrigger while busy; done ends the operation
  assert_no_retrigger_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !start_pulse_o);
  assert_done_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done_i && busy_o) |=> (!busy_o && !host_wait_o));
endmodule

// File: rtl/blt_param_regs.sv
module blt_param_regs
  import blt_regs_pkg::*;
#(
  parameter int COLOR_BYTES        = 4,
  parameter int NARROW_COLOR_BYTES = 2,
  parameter int WIDE_WIDTH_BITS    = 13,
  parameter int NARROW_WIDTH_BITS  = 11,
  parameter int HEIGHT_BITS        = 10,
  parameter int PITCH_BITS         = 16,
  parameter int WIDE_ADDR_BITS     = 22,
  parameter int NARROW_ADDR_BITS   = 21,
  localparam int COLOR_W = COLOR_BYTES * 8
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wide_sel,
  input  logic                       mm_we,
  input  logic [7:0]                 mm_addr,
  input  logic [7:0]                 mm_wdata,
  input  logic                       gc_we,
  input  logic [7:0]                 gc_index,
  input  logic [7:0]                 gc_wdata,
  input  logic                       op_done,
  output logic [COLOR_W-1:0]         bg_color,
  output logic [COLOR_W-1:0]         fg_color,
  output logic [WIDE_WIDTH_BITS-1:0] xfer_width,
  output logic [HEIGHT_BITS-1:0]     xfer_height,
  output logic [PITCH_BITS-1:0]      dst_pitch,
  output logic [PITCH_BITS-1:0]      src_pitch,
  output logic [WIDE_ADDR_BITS-1:0]  dst_addr,
  output logic [WIDE_ADDR_BITS-1:0]  src_addr,
  output logic [7:0]                 xfer_mode,
  output logic [7:0]                 xfer_rop,
  output logic                       start_pulse,
  output logic                       busy,
  output logic                       host_wait,
  output logic [WIDE_ADDR_BITS-1:0]  dst_addr_saved,
  output logic [WIDE_ADDR_BITS-1:0]  src_addr_saved
);
  logic       alias_hit;
  logic [7:0] alias_off;
  byte_wr_t   wr;

  blt_alias_map u_alias (
    .idx_i (gc_index),
    .hit_o (alias_hit),
    .off_o (alias_off)
  );

  // R13: the memory-mapped port wins a same-cycle collision
  always_comb begin
    if (mm_we) begin
      wr.en   = 1'b1;
      wr.off  = mm_addr;
      wr.data = mm_wdata;
    end else begin
      wr.en   = gc_we && alias_hit;
      wr.off  = alias_off;
      wr.data = gc_wdata;
    end
  end

  blt_field_bank #(
    .COLOR_BYTES        (COLOR_BYTES),
    .NARROW_COLOR_BYTES (NARROW_COLOR_BYTES),
    .WIDE_WIDTH_BITS    (WIDE_WIDTH_BITS),
    .NARROW_WIDTH_BITS  (NARROW_WIDTH_BITS),
    .HEIGHT_BITS        (HEIGHT_BITS),
    .PITCH_BITS         (PITCH_BITS),
    .WIDE_ADDR_BITS     (WIDE_ADDR_BITS),
    .NARROW_ADDR_BITS   (NARROW_ADDR_BITS)
  ) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_sel    (wide_sel),
    .wr          (wr),
    .bg_o        (bg_color),
    .fg_o        (fg_color),
    .width_o     (xfer_width),
    .height_o    (xfer_height),
    .dst_pitch_o (dst_pitch),
    .src_pitch_o (src_pitch),
    .dst_addr_o  (dst_addr),
    .src_addr_o  (src_addr),
    .mode_o      (xfer_mode),
    .rop_o       (xfer_rop)
  );

  blt_launch_ctl #(.ADDR_W(WIDE_ADDR_BITS)) u_launch (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctrl_wr_i     (wr.en && wr.off == OFF_CTRL),
    .ctrl_data_i   (wr.data),
    .mode_i        (xfer_mode),
    .dst_addr_i    (dst_addr),
    .src_addr_i    (src_addr),
    .op_done_i     (op_done),
    .start_pulse_o (start_pulse),
    .busy_o        (busy),
    .host_wait_o   (host_wait),
    .dst_saved_o   (dst_addr_saved),
    .src_saved_o   (src_addr_saved)
  );

  // R13: indexed write is dropped when both ports strobe together
  assert_mm_priority_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_we && gc_we && mm_addr == OFF_ROP) |=> (xfer_rop == $past(mm_wdata)));
endmodule

// File: tb/blt_param_regs_tb.sv
module blt_param_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_sel = 1'b0;
  logic mm_we = 1'b0, gc_we = 1'b0, op_done = 1'b0;
  logic [7:0] mm_addr = '0, mm_wdata = '0, gc_index = '0, gc_wdata = '0;
  logic [31:0] bg_color, fg_color;
  logic [12:0] xfer_width;
  logic [9:0]  xfer_height;
  logic [15:0] dst_pitch, src_pitch;
  logic [21:0] dst_addr, src_addr, dst_addr_saved, src_addr_saved;
  logic [7:0]  xfer_mode, xfer_rop;
  logic start_pulse, busy, host_wait;

  always #4 clk = ~clk;

  blt_param_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wide_sel(wide_sel),
    .mm_we(mm_we), .mm_addr(mm_addr), .mm_wdata(mm_wdata),
    .gc_we(gc_we), .gc_index(gc_index), .gc_wdata(gc_wdata),
    .op_done(op_done),
    .bg_color(bg_color), .fg_color(fg_color),
    .xfer_width(xfer_width), .xfer_height(xfer_height),
    .dst_pitch(dst_pitch), .src_pitch(src_pitch),
    .dst_addr(dst_addr), .src_addr(src_addr),
    .xfer_mode(xfer_mode), .xfer_rop(xfer_rop),
    .start_pulse(start_pulse), .busy(busy), .host_wait(host_wait),
    .dst_addr_saved(dst_addr_saved), .src_addr_saved(src_addr_saved)
  );

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_bg, m_fg;
  logic [12:0] m_w;
  logic [9:0]  m_h;
  logic [15:0] m_dp, m_sp;
  logic [21:0] m_da, m_sa, m_dsv, m_ssv;
  logic [7:0]  m_mode, m_rop, m_off, m_d;
  logic m_pulse, m_busy, m_host, m_hit, m_go;
  int lane;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bg = 0; m_fg = 0; m_w = 0; m_h = 0; m_dp = 0; m_sp = 0;
      m_da = 0; m_sa = 0; m_dsv = 0; m_ssv = 0; m_mode = 0; m_rop = 0;
      m_pulse = 0; m_busy = 0; m_host = 0;
    end else begin
      m_hit = 1'b1; m_off = mm_addr; m_d = mm_wdata;
      if (!mm_we) begin
        m_d = gc_wdata;
        case (gc_index)
          8'h00: m_off = 8'h00;  8'h01: m_off = 8'h01;
          8'h10: m_off = 8'h04;  8'h11: m_off = 8'h05;
          8'h12: m_off = 8'h02;  8'h13: m_off = 8'h06;
          8'h14: m_off = 8'h03;  8'h15: m_off = 8'h07;
          8'h20: m_off = 8'h08;
          default: m_hit = 1'b0;
        endcase
        m_hit = m_hit && gc_we;
      end
      m_go = m_hit && m_off == 8'h1C && m_d[1] && !m_busy;
      m_pulse = m_go && !m_mode[2];
      if (m_go) begin
        m_busy = 1'b1;
        if (m_mode[2]) begin m_host = 1'b1; m_dsv = m_da; m_ssv = m_sa; end
      end else if (op_done) begin
        m_busy = 1'b0; m_host = 1'b0;
      end
      if (m_hit) begin
        lane = int'(m_off) % 4;
        if (m_off < 8'h08 && (wide_sel || lane < 2)) begin
          if (m_off < 8'h04) m_bg[8*lane +: 8] = m_d;
          else               m_fg[8*lane +: 8] = m_d;
        end
        case (m_off)
          8'h08: m_w[7:0] = m_d;
          8'h09: m_w[12:8] = wide_sel ? m_d[4:0] : {2'b00, m_d[2:0]};
          8'h0A: m_h[7:0] = m_d;
          8'h0B: m_h[9:8] = m_d[1:0];
          8'h0C: m_dp[7:0] = m_d;
          8'h0D: m_dp[15:8] = m_d;
          8'h0E: m_sp[7:0] = m_d;
          8'h0F: m_sp[15:8] = m_d;
          8'h10: m_da[7:0] = m_d;
          8'h11: m_da[15:8] = m_d;
          8'h12: m_da[21:16] = wide_sel ? m_d[5:0] : {1'b0, m_d[4:0]};
          8'h14: m_sa[7:0] = m_d;
          8'h15: m_sa[15:8] = m_d;
          8'h16: m_sa[21:16] = wide_sel ? m_d[5:0] : {1'b0, m_d[4:0]};
          8'h18: m_mode = m_d;
          8'h1A: m_rop = m_d;
          default: ;
        endcase
      end
    end
  end

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 bg_color", bg_color, m_bg);
      chk("R2 fg_color", fg_color, m_fg);
      chk("R4 xfer_width", 32'(xfer_width), 32'(m_w));
      chk("R5 xfer_height", 32'(xfer_height), 32'(m_h));
      chk("R6 dst_pitch", 32'(dst_pitch), 32'(m_dp));
      chk("R6 src_pitch", 32'(src_pitch), 32'(m_sp));
      chk("R7 dst_addr", 32'(dst_addr), 32'(m_da));
      chk("R7 src_addr", 32'(src_addr), 32'(m_sa));
      chk("R8 xfer_mode", 32'(xfer_mode), 32'(m_mode));
      chk("R8 xfer_rop", 32'(xfer_rop), 32'(m_rop));
      chk("R10 start_pulse", 32'(start_pulse), 32'(m_pulse));
      chk("R12 busy", 32'(busy), 32'(m_busy));
      chk("R11 host_wait", 32'(host_wait), 32'(m_host));
      chk("R11 dst_addr_saved", 32'(dst_addr_saved), 32'(m_dsv));
      chk("R11 src_addr_saved", 32'(src_addr_saved), 32'(m_ssv));
    end
  end

  task automatic mm_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); mm_we = 1'b1; mm_addr = a; mm_wdata = d;
    @(negedge clk); mm_we = 1'b0;
  endtask

  task automatic gc_wr(input logic [7:0] i, input logic [7:0] d);
    @(negedge clk); gc_we = 1'b1; gc_index = i; gc_wdata = d;
    @(negedge clk); gc_we = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic do_reset(input logic w);
    @(negedge clk); rst_n = 1'b0; wide_sel = w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    // ---------------- narrow variant ----------------
    do_reset(1'b0);
    chk("R1 reset bg", bg_color, 32'h0);
    chk("R1 reset width", 32'(xfer_width), 32'h0);
    chk("R1 reset busy/pulse", {30'b0, busy, start_pulse}, 32'h0);
    chk("R1 reset saved", 32'(dst_addr_saved), 32'h0);

    mm_wr(8'h00, 8'h11); mm_wr(8'h01, 8'h22); mm_wr(8'h02, 8'h33); mm_wr(8'h03, 8'h44);
    chk("R3 narrow bg ignores upper lanes", bg_color, 32'h0000_2211);
    mm_wr(8'h04, 8'h55); mm_wr(8'h05, 8'h66); mm_wr(8'h06, 8'h77); mm_wr(8'h07, 8'h88);
    chk("R3 narrow fg ignores upper lanes", fg_color, 32'h0000_6655);
    mm_wr(8'h08, 8'hAB); mm_wr(8'h09, 8'hFF);
    chk("R4 narrow width mask", 32'(xfer_width), 32'h07AB);
    mm_wr(8'h0A, 8'h34); mm_wr(8'h0B, 8'hFF);
    chk("R5 height mask", 32'(xfer_height), 32'h0334);
    mm_wr(8'h0C, 8'h40); mm_wr(8'h0D, 8'h01); mm_wr(8'h0E, 8'h80); mm_wr(8'h0F, 8'h02);
    chk("R6 pitches", {dst_pitch, src_pitch}, 32'h0140_0280);
    mm_wr(8'h10, 8'h01); mm_wr(8'h11, 8'h02); mm_wr(8'h12, 8'hFF);
    chk("R7 narrow dst addr mask", 32'(dst_addr), 32'h001F_0201);
    mm_wr(8'h14, 8'hAA); mm_wr(8'h15, 8'hBB); mm_wr(8'h16, 8'h3C);
    chk("R7 narrow src addr mask", 32'(src_addr), 32'h001C_BBAA);
    mm_wr(8'h1A, 8'hCC);
    chk("R8 rop", 32'(xfer_rop), 32'h00CC);

    gc_wr(8'h14, 8'h99);
    chk("R3 alias to narrow upper lane ignored", bg_color, 32'h0000_2211);
    gc_wr(8'h00, 8'h5A);
    chk("R9 alias index 0x00", bg_color, 32'h0000_225A);
    gc_wr(8'h11, 8'h9D);
    chk("R9 alias index 0x11", fg_color, 32'h0000_9D55);
    gc_wr(8'h20, 8'h01);
    chk("R9 alias index 0x20", 32'(xfer_width), 32'h0701);
    gc_wr(8'h33, 8'hEE);
    chk("R9 unmapped index", {bg_color[15:0], fg_color[15:0]}, 32'h225A_9D55);

    mm_wr(8'h1C, 8'hFD);
    chk("R10 control without go bit", {30'b0, busy, start_pulse}, 32'h0);
    mm_wr(8'h1C, 8'h02);
    chk("R10 go pulse and busy", {30'b0, busy, start_pulse}, 32'h3);
    @(negedge clk);
    chk("R10 pulse is one cycle", 32'(start_pulse), 32'h0);
    mm_wr(8'h1A, 8'h3E);
    chk("R12 field write while busy", 32'(xfer_rop), 32'h003E);
    mm_wr(8'h1C, 8'h02);
    chk("R12 no retrigger while busy", {30'b0, busy, start_pulse}, 32'h2);
    done_pulse();
    chk("R12 done clears busy", 32'(busy), 32'h0);

    mm_wr(8'h18, 8'h04);
    mm_wr(8'h1C, 8'h02);
    chk("R11 host launch flags", {29'b0, host_wait, busy, start_pulse}, 32'h6);
    chk("R11 dst snapshot", 32'(dst_addr_saved), 32'h001F_0201);
    chk("R11 src snapshot", 32'(src_addr_saved), 32'h001C_BBAA);
    done_pulse();
    chk("R12 done clears host wait", {30'b0, host_wait, busy}, 32'h0);

    @(negedge clk);
    mm_we = 1'b1; mm_addr = 8'h1A; mm_wdata = 8'h77;
    gc_we = 1'b1; gc_index = 8'h20; gc_wdata = 8'h55;
    @(negedge clk); mm_we = 1'b0; gc_we = 1'b0;
    chk("R13 mm write taken", 32'(xfer_rop), 32'h0077);
    chk("R13 indexed write dropped", 32'(xfer_width), 32'h0701);

    // ---------------- wide variant ----------------
    do_reset(1'b1);
    chk("R1 reset after wide strap", {bg_color[15:0], 3'b0, xfer_width}, 32'h0);
    mm_wr(8'h00, 8'h11); mm_wr(8'h01, 8'h22); mm_wr(8'h02, 8'h33); mm_wr(8'h03, 8'h44);
    chk("R2 wide bg bytes", bg_color, 32'h4433_2211);
    mm_wr(8'h08, 8'hAB); mm_wr(8'h09, 8'hFF);
    chk("R4 wide width mask", 32'(xfer_width), 32'h1FAB);
    mm_wr(8'h10, 8'h01); mm_wr(8'h11, 8'h02); mm_wr(8'h12, 8'hFF);
    chk("R7 wide dst addr mask", 32'(dst_addr), 32'h003F_0201);
    mm_wr(8'h16, 8'hFF);
    chk("R7 wide src addr mask", 32'(src_addr), 32'h003F_0000);
    gc_wr(8'h13, 8'hE1); gc_wr(8'h15, 8'h7F);
    chk("R9 alias wide fg upper", fg_color, 32'h7FE1_0000);
    gc_wr(8'h12, 8'hC3);
    chk("R9 alias wide bg byte 2", bg_color, 32'h44C3_2211);
    mm_wr(8'h18, 8'h5A);
    chk("R8 mode byte", 32'(xfer_mode), 32'h005A);
    done_pulse();
    mm_wr(8'h1C, 8'h02);
    chk("R10 wide go pulse", {30'b0, busy, start_pulse}, 32'h3);
    done_pulse();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule